// File: doc/BRIEF.md
# Compare-and-Reload Waveform Timer

This block is a parameterized up-counter with an auto-reload limit and a compare threshold, driving a single waveform pin. A count is launched by a one-cycle single-start or continuous-start strobe, or by a rising edge on an external trigger input. In single mode the counter runs once from zero up to the auto-reload value and then parks at zero. In continuous mode it wraps to zero and keeps going. Either strobe may arrive while a count is in progress, and it then only changes the counting mode for the rest of the run.

The waveform pin has three shapes. The first is a repeating PWM pulse that rises on the compare match and falls on the reload match. The second is a one-time pulse that is suppressed after the first reload match. The third is a latched level that rises on the compare match and holds. A polarity input inverts the final pin. Taking the enable low clears the counter, stops counting and returns the pin to its inactive level. Software must keep the auto-reload value strictly above the compare value for meaningful waveforms.

Top module: `wave_timer`

## Requirements
- R1: While `enable` is low, `count` is 0 one cycle later, the waveform level is inactive, and start strobes and trigger edges have no effect; counting mode returns to single.
- R2: With `enable` high and the counter idle, a `startSingle` or `startCont` pulse, or a 0-to-1 change of `trigIn`, starts a run: `count` shows 0 after that edge and then rises by one per clock.
- R3: After `count` shows the `autoReload` value, the next edge puts it at 0; in single mode it then stays at 0 (idle), in continuous mode it keeps counting.
- R4: A `startSingle` pulse during a continuous run switches to single mode, so the run stops at the next reload match; a `startCont` pulse during a single run makes it wrap and continue; if both pulse in the same cycle, single mode is taken.
- R5: A trigger edge while a run is in progress does not restart or alter the count; a trigger-started run uses the current mode, which is single after reset or after a disable.
- R6: With `outModeSel` = 0 in continuous mode, the level goes active on the edge after `count` shows `compare` and inactive on the edge after `count` shows `autoReload`.
- R7: With `outModeSel` = 0 in single mode, once a reload match has occurred since the run started, later compare matches no longer activate the level.
- R8: With `outModeSel` = 1, the level goes active on the edge after a compare match and stays active through reload matches until the next start from idle or a disable.
- R9: `waveOut` equals the internal level XOR `polaritySel`, so the inactive pin level equals `polaritySel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timer enable; low clears and stops the timer |
| startSingle | input | 1 | One-cycle strobe: start or switch to single mode |
| startCont | input | 1 | One-cycle strobe: start or switch to continuous mode |
| trigIn | input | 1 | External trigger; a rising edge starts an idle timer |
| autoReload | input | CNT_W | Reload limit of the counter |
| compare | input | CNT_W | Compare threshold |
| outModeSel | input | 1 | 0: PWM / single pulse, 1: latched set level |
| polaritySel | input | 1 | Inverts the waveform pin |
| count | output | CNT_W | Current counter value |
| waveOut | output | 1 | Waveform output |

## Verification
The hardest states to reach are the mode switches in the middle of a run. An example is a single-start that arrives after the first wrap of a continuous PWM run: it must both stop the counter at the next reload and suppress the compare pulse in between. Trigger edges that land during a run are another. Directed sequences set up each of these cases with exact count and pin values at known cycles. A long random phase then mixes sparse strobes, trigger toggles, enable drops and mode and polarity changes. In that phase a cycle-level reference model in the bench is compared on every cycle.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_CONT   = 1'b1
  } cntMode_t;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic clearAll;
    logic restart;
    logic countUp;
    logic wrapZero;
    logic setWave;
    logic clearWave;
  } dpStrobe_t;
endpackage

// File: rtl/wave_timer_ctrl.sv
module wave_timer_ctrl
  import wave_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      startSingle,
  input  logic      startCont,
  input  logic      trigIn,
  input  logic      outModeSel,
  input  logic      matchCmp,
  input  logic      matchArr,
  output dpStrobe_t strobe,
  output logic      running
);
  cntMode_t mode, modeNext;
  logic trigPrev, pulseDone;
  logic trigEdge, startReq, inhibitSet, reloadHit;

  always_comb begin
    trigEdge = trigIn & ~trigPrev;
    if (startSingle)     modeNext = MODE_SINGLE;
    else if (startCont)  modeNext = MODE_CONT;
    else                 modeNext = mode;
    startReq   = enable & ~running & (startSingle | startCont | trigEdge);
    reloadHit  = enable & running & matchArr;
    inhibitSet = ~outModeSel & (modeNext == MODE_SINGLE) & pulseDone;
    strobe           = '0;
    strobe.clearAll  = ~enable;
    strobe.restart   = startReq;
    strobe.countUp   = enable & running & ~matchArr;
    strobe.wrapZero  = reloadHit;
    strobe.setWave   = enable & running & matchCmp & ~inhibitSet;
    strobe.clearWave = reloadHit & ~outModeSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_SINGLE;
      running   <= 1'b0;
      trigPrev  <= 1'b0;
      pulseDone <= 1'b0;
    end else begin
      trigPrev <= trigIn;
      if (!enable) begin
        mode      <= MODE_SINGLE;
        running   <= 1'b0;
        pulseDone <= 1'b0;
      end else begin
        mode <= modeNext;
        if (startReq) begin
          running   <= 1'b1;
          pulseDone <= 1'b0;
        end else if (reloadHit) begin
          pulseDone <= 1'b1;
          if (modeNext == MODE_SINGLE) running <= 1'b0;
        end
      end
    end
  end

  // R1: a low enable halts any run
  a_r1_stop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !running);

  // R5: mid-run, only a reload match can end the run
  a_r5_run_until_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && !matchArr) |=> running);

  // R3: continuous mode never ends a run at a reload match
  a_r3_cont_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && matchArr && mode == MODE_CONT && !startSingle) |=> running);
endmodule

// File: rtl/wave_timer_dp.sv
module wave_timer_dp
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] autoReload,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] count,
  output logic             matchCmp,
  output logic             matchArr,
  output logic             waveLevel
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assign matchCmp = (count == compare);
  assign matchArr = (count == autoReload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strobe.clearAll || strobe.restart || strobe.wrapZero) begin
      count <= '0;
    end else if (strobe.countUp) begin
      count <= count + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waveLevel <= 1'b0;
    end else if (strobe.clearAll || strobe.restart) begin
      waveLevel <= 1'b0;
    end else if (strobe.setWave) begin
      waveLevel <= 1'b1;
    end else if (strobe.clearWave) begin
      waveLevel <= 1'b0;
    end
  end

  // R2: the counter advances by exactly one on a count strobe
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.countUp && !strobe.clearAll) |=> (count == $past(count) + CNT_ONE));
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             startSingle,
  input  logic             startCont,
  input  logic             trigIn,
  input  logic [CNT_W-1:0] autoReload,
  input  logic [CNT_W-1:0] compare,
  input  logic             outModeSel,
  input  logic             polaritySel,
  output logic [CNT_W-1:0] count,
  output logic             waveOut
);
  dpStrobe_t strobe;
  logic running, matchCmp, matchArr, waveLevel;

  wave_timer_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .startSingle (startSingle),
    .startCont   (startCont),
    .trigIn      (trigIn),
    .outModeSel  (outModeSel),
    .matchCmp    (matchCmp),
    .matchArr    (matchArr),
    .strobe      (strobe),
    .running     (running)
  );

  wave_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .autoReload (autoReload),
    .compare    (compare),
    .count      (count),
    .matchCmp   (matchCmp),
    .matchArr   (matchArr),
    .waveLevel  (waveLevel)
  );

  assign waveOut = waveLevel ^ polaritySel;

  // R1: a disable clears the counter on the next edge
  a_r1_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0));

  // R6: in PWM shape the pin is inactive right after a reload match
  a_r6_fall_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && count == autoReload && !outModeSel) |=> (waveOut == polaritySel));

  // R8: in set shape an active level holds while the run continues
  a_r8_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && outModeSel && waveLevel) |=> waveLevel);
endmodule

// File: tb/tb_wave_timer.sv
module tb_wave_timer;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ss = 1'b0, sc = 1'b0, trg = 1'b0, oms = 1'b0, pol = 1'b0;
  logic [W-1:0] arr = 32'd9, cmp = 32'd4;
  logic [W-1:0] count;
  logic waveOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic [W-1:0] mCnt = '0;
  logic mRun = 1'b0, mCont = 1'b0, mRaw = 1'b0, mDone = 1'b0, mTrigPrev = 1'b0;

  always #5 clk = ~clk;

  wave_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(en), .startSingle(ss), .startCont(sc),
    .trigIn(trg), .autoReload(arr), .compare(cmp), .outModeSel(oms),
    .polaritySel(pol), .count(count), .waveOut(waveOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkCnt(input string tag, input logic [W-1:0] exp);
    chk(count == exp, tag, count, exp);
  endtask

  task automatic chkWave(input string tag, input logic exp);
    chk(waveOut == exp, tag, {31'd0, waveOut}, {31'd0, exp});
  endtask

  // Reference model: one clock of behaviour written from the requirements
  task automatic modelStep();
    logic edgeSeen, newCont, inhibit, nextRaw;
    edgeSeen = trg & ~mTrigPrev;
    mTrigPrev = trg;
    if (!en) begin
      mCnt = '0; mRun = 0; mCont = 0; mRaw = 0; mDone = 0;
    end else begin
      newCont = ss ? 1'b0 : (sc ? 1'b1 : mCont);
      if (!mRun) begin
        if (ss || sc || edgeSeen) begin
          mRun = 1; mCnt = '0; mRaw = 0; mDone = 0;
        end
      end else begin
        inhibit = !oms && !newCont && mDone;
        nextRaw = mRaw;
        if (mCnt == cmp && !inhibit) nextRaw = 1'b1;
        else if (mCnt == arr && !oms) nextRaw = 1'b0;
        if (mCnt == arr) begin
          mCnt = '0; mDone = 1;
          if (!newCont) mRun = 0;
        end else begin
          mCnt = mCnt + 1;
        end
        mRaw = nextRaw;
      end
      mCont = newCont;
    end
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    ss = 1'b0;
    sc = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chkCnt("R1 reset count", 0);
    chkWave("R1 reset wave", 1'b0);

    // R1: strobes and trigger ignored while disabled
    sc = 1; tick();
    trg = 1; ticks(2);
    chkCnt("R1 strobe ignored when disabled", 0);
    chkWave("R1 wave inactive when disabled", 1'b0);

    // R2/R6: continuous PWM, arr=9 cmp=4
    en = 1; trg = 0; tick();
    sc = 1; tick();
    chkCnt("R2 start shows zero", 0);
    ticks(4);
    chkCnt("R2 counting", 4);
    chkWave("R6 low before compare", 1'b0);
    tick();
    chkWave("R6 rise after compare", 1'b1);
    ticks(4);
    chkCnt("R2 at reload", 9);
    chkWave("R6 high at reload", 1'b1);
    tick();
    chkCnt("R3 wrap to zero", 0);
    chkWave("R6 fall after reload", 1'b0);
    tick();
    chkCnt("R3 continuous keeps counting", 1);

    // R5: trigger edge during run is ignored
    trg = 1; tick();
    chkCnt("R5 trigger ignored mid-run", 2);

    // R7 + R4: switch to single after first wrap, compare pulse suppressed
    ss = 1; tick();
    ticks(3);
    chkCnt("R7 past compare", 6);
    chkWave("R7 pulse suppressed", 1'b0);
    ticks(3);
    tick();
    chkCnt("R4 single switch stops", 0);
    ticks(3);
    chkCnt("R4 stays idle", 0);

    // R5/R3: trigger start in single mode, stops after one run
    trg = 0; tick();
    trg = 1; tick();
    ticks(5);
    chkCnt("R5 trigger started", 5);
    chkWave("R6 single-run pulse", 1'b1);
    ticks(5);
    chkCnt("R3 single stops at zero", 0);
    chkWave("R6 single-run pulse ends", 1'b0);
    ticks(2);
    chkCnt("R3 single idle", 0);

    // R8: set shape holds through wrap
    oms = 1; sc = 1; tick();
    ticks(5);
    chkWave("R8 set rise", 1'b1);
    ticks(5);
    chkCnt("R8 wrapped", 0);
    chkWave("R8 holds through reload", 1'b1);
    // R4: single strobe during continuous run stops it at the next reload
    ss = 1; tick();
    ticks(9);
    chkCnt("R4 cont-to-single stop", 0);
    chkWave("R8 held after stop", 1'b1);

    // R1: disable clears
    en = 0; tick();
    chkCnt("R1 disable clears count", 0);
    chkWave("R1 disable clears wave", 1'b0);

    // R9: polarity
    pol = 1; tick();
    chkWave("R9 inactive equals polarity", 1'b1);
    en = 1; tick();
    // R4: both strobes together -> single
    ss = 1; sc = 1; tick();
    ticks(5);
    chkWave("R9 active inverted", 1'b0);
    ticks(5);
    chkCnt("R4 both strobes give single", 0);
    ticks(2);
    chkCnt("R4 single idle after both", 0);

    // Random phase against the model
    oms = 0; pol = 0;
    for (int i = 0; i < 6000; i++) begin
      en  = ($urandom % 100) != 0;
      ss  = ($urandom % 40) == 0;
      sc  = ($urandom % 40) == 0;
      if (($urandom % 8) == 0) trg = ~trg;
      if (($urandom % 300) == 0) oms = ~oms;
      if (($urandom % 300) == 0) pol = ~pol;
      if (!mRun && ($urandom % 50) == 0) begin
        arr = 32'd2 + ($urandom % 14);
        cmp = $urandom % arr;
      end
      modelStep();
      @(posedge clk);
      @(negedge clk);
      chkCnt("R2 R3 model count", mCnt);
      chkWave("R6 R7 R8 model wave", mRaw ^ pol);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule